// File: doc/BRIEF.md
# Character LCD Byte Write Engine

This block is the lowest layer of a parallel 8-bit character display interface. A client presents one byte, a bit that marks it as a command or as display data, and a 2-bit code that picks how long the display controller needs to digest it. A single-cycle execute strobe starts the transfer. The engine places the byte and the register-select level on the pins and lets them settle. It then pulses the enable line for the minimum high time and keeps the bus steady for the hold time. After that it waits out the chosen delay and raises ready again. The display's busy flag is never read. The wait is fixed per transfer by the delay code, and the read/write line stays at write.

After reset the engine waits at least 20 ms so that the display can power up. It then raises an initialised flag together with ready. Every cycle count (setup, enable width, hold, the four delays and the power-up wait) is computed at elaboration from a clock-frequency parameter given in kHz. Each count is rounded up and is never less than one cycle.

The sequencer has six states. POWERUP moves to IDLE when the power-up wait ends. IDLE moves to SETUP on an execute strobe. SETUP moves to PULSE, PULSE moves to HOLD and HOLD moves to DELAY, each when its own count expires. DELAY returns to IDLE when the selected delay expires. Ready is high only in IDLE, and the enable pin is high only in PULSE.

Top module: `lcdw_byte_driver`

## Requirements
- R1: Reset is active low and asynchronous. While it is low, lcd_e = 0, lcd_data = 0x00, lcd_rs = 0, ready = 0 and initialised = 0.
- R2: ready and initialised both rise on the Nth rising clock edge after reset release, where N = ceil(20 ms × CLK_KHZ). They never rise earlier. Once set, initialised stays high until the next reset.
- R3: An execute strobe sampled at a rising edge while ready = 1 is accepted. ready is 0 from that same edge on.
- R4: At the accepting edge, lcd_data takes the word and lcd_rs takes the select bit (0 = command, 1 = display data). Both keep those values until the next accepted strobe.
- R5: lcd_e rises SETUP edges after the accepting edge and stays high for exactly PULSE cycles. SETUP = ceil(40 ns), PULSE = ceil(230 ns) and HOLD = ceil(10 ns), each at least one cycle. lcd_e is never high while ready is high.
- R6: After lcd_e falls, ready stays low for HOLD plus the delay that the code selects: 00 = 4 µs, 01 = 100 µs, 10 = 4 ms, 11 = 20 ms, each rounded up to whole cycles.
- R7: An execute strobe while ready = 0 (during the power-up wait or during a transfer) is ignored. It causes no enable pulse, and lcd_data and lcd_rs do not change.
- R8: lcd_rw is 0 at all times.
- R9: lcd_data and lcd_rs do not change while lcd_e is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 8 | Byte to write |
| cmd_is_data | input | 1 | 0 = command, 1 = display data; becomes lcd_rs |
| cmd_exec | input | 1 | One-cycle execute strobe |
| cmd_delay | input | 2 | Post-write delay code |
| ready | output | 1 | Engine idle and able to accept a strobe |
| initialised | output | 1 | Power-up wait has completed |
| lcd_rs | output | 1 | Register-select pin |
| lcd_rw | output | 1 | Read/write pin, always write (0) |
| lcd_e | output | 1 | Enable strobe pin |
| lcd_data | output | 8 | Data bus pins |

## Verification
Each result has a known due time. ready must read low at the first sample after the accepting edge. Enable rises SETUP cycles after acceptance and must measure exactly PULSE samples high. ready must then stay low for exactly HOLD plus the selected delay in samples, and the end of the power-up wait is due on an exact edge count after reset release. The bench drives and samples on falling edges. A monitor measures each enable pulse and the ready gap that follows it in whole samples, and compares them with the item the driver queued when it issued the strobe. An ignored strobe would produce a pulse that has no queued item, and the monitor reports that as a failure.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_DELAY
    } lcdw_state_e;

    // Post-write delay selector values
    localparam logic [1:0] DLY_4US   = 2'b00;
    localparam logic [1:0] DLY_100US = 2'b01;
    localparam logic [1:0] DLY_4MS   = 2'b10;
    localparam logic [1:0] DLY_20MS  = 2'b11;

    // Convert a duration in ns to clock cycles, rounding up, minimum one.
    function automatic longint ns_to_cyc(input longint ns, input longint khz);
        longint c;
        c = (ns * khz + 64'd999999) / 64'd1000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int unsigned        CNT_W   = 16,
    parameter logic [CNT_W-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/lcdw_delay_sel.sv
module lcdw_delay_sel #(
    parameter int unsigned      CNT_W = 16,
    parameter logic [CNT_W-1:0] LD0   = '0,
    parameter logic [CNT_W-1:0] LD1   = '0,
    parameter logic [CNT_W-1:0] LD2   = '0,
    parameter logic [CNT_W-1:0] LD3   = '0
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] load_val
);
    import lcdw_pkg::*;

    always_comb begin
        unique case (code)
            DLY_4US:   load_val = LD0;
            DLY_100US: load_val = LD1;
            DLY_4MS:   load_val = LD2;
            default:   load_val = LD3;
        endcase
    end

endmodule

// File: rtl/lcdw_fsm.sv
module lcdw_fsm #(
    parameter int unsigned      CNT_W    = 16,
    parameter logic [CNT_W-1:0] LD_SETUP = '0,
    parameter logic [CNT_W-1:0] LD_PULSE = '0,
    parameter logic [CNT_W-1:0] LD_HOLD  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmd_word,
    input  logic             cmd_is_data,
    input  logic             cmd_exec,
    input  logic [1:0]       cmd_delay,
    input  logic             tmr_zero,
    input  logic [CNT_W-1:0] dly_load,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic [1:0]       dly_code_q,
    output logic             ready_o,
    output logic             init_o,
    output logic             e_o,
    output logic             rs_o,
    output logic [7:0]       data_o
);
    import lcdw_pkg::*;

    lcdw_state_e st, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_POWERUP;
        else        st <= nxt;
    end

    // next state and timer loads
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_POWERUP: if (tmr_zero) nxt = ST_IDLE;
            ST_IDLE: if (cmd_exec) begin
                nxt      = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = LD_SETUP;
            end
            ST_SETUP: if (tmr_zero) begin
                nxt      = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_PULSE;
            end
            ST_PULSE: if (tmr_zero) begin
                nxt      = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = LD_HOLD;
            end
            ST_HOLD: if (tmr_zero) begin
                nxt      = ST_DELAY;
                tmr_load = 1'b1;
                tmr_val  = dly_load;
            end
            ST_DELAY: if (tmr_zero) nxt = ST_IDLE;
            default: nxt = ST_POWERUP;
        endcase
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_o    <= 1'b0;
            init_o     <= 1'b0;
            e_o        <= 1'b0;
            rs_o       <= 1'b0;
            data_o     <= '0;
            dly_code_q <= '0;
        end else begin
            ready_o <= (nxt == ST_IDLE);
            e_o     <= (nxt == ST_PULSE);
            if (st == ST_POWERUP && nxt == ST_IDLE) init_o <= 1'b1;
            if (st == ST_IDLE && cmd_exec) begin
                rs_o       <= cmd_is_data;
                data_o     <= cmd_word;
                dly_code_q <= cmd_delay;
            end
        end
    end

    // R3: an accepted strobe drops ready at once
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && cmd_exec) |=> !ready_o);

    // R7: bus is untouched across any edge where the engine is busy
    a_r7_busy_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ($stable(data_o) && $stable(rs_o)));

    // R9: bus steady while enable is high
    a_r9_stable_under_e: assert property (@(posedge clk) disable iff (!rst_n)
        e_o |-> ($stable(data_o) && $stable(rs_o)));

    // R2: initialised is sticky and rises with ready
    a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> init_o);
    a_r2_init_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_o) |-> ready_o);

    // R6: delay not cut short
    a_r6_delay_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DELAY && !tmr_zero) |=> (st == ST_DELAY && !ready_o));

endmodule

// File: rtl/lcdw_byte_driver.sv
module lcdw_byte_driver #(
    parameter int unsigned CLK_KHZ = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd_word,
    input  logic       cmd_is_data,
    input  logic       cmd_exec,
    input  logic [1:0] cmd_delay,
    output logic       ready,
    output logic       initialised,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_data
);
    import lcdw_pkg::*;

    localparam longint KHZ       = longint'(CLK_KHZ);
    localparam longint CYC_SETUP = ns_to_cyc(40, KHZ);
    localparam longint CYC_PULSE = ns_to_cyc(230, KHZ);
    localparam longint CYC_HOLD  = ns_to_cyc(10, KHZ);
    localparam longint CYC_D0    = ns_to_cyc(4000, KHZ);
    localparam longint CYC_D1    = ns_to_cyc(100000, KHZ);
    localparam longint CYC_D2    = ns_to_cyc(4000000, KHZ);
    localparam longint CYC_D3    = ns_to_cyc(20000000, KHZ);
    localparam longint CYC_PWR   = CYC_D3;
    localparam int     CNT_W     = $clog2(CYC_PWR + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(CYC_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(CYC_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(CYC_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_D0    = CNT_W'(CYC_D0 - 1);
    localparam logic [CNT_W-1:0] LD_D1    = CNT_W'(CYC_D1 - 1);
    localparam logic [CNT_W-1:0] LD_D2    = CNT_W'(CYC_D2 - 1);
    localparam logic [CNT_W-1:0] LD_D3    = CNT_W'(CYC_D3 - 1);
    localparam logic [CNT_W-1:0] LD_PWR   = CNT_W'(CYC_PWR - 1);

    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val, dly_load;
    logic [1:0]       dly_code_q;

    lcdw_timer #(.CNT_W(CNT_W), .RST_VAL(LD_PWR)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    lcdw_delay_sel #(.CNT_W(CNT_W), .LD0(LD_D0), .LD1(LD_D1),
                     .LD2(LD_D2), .LD3(LD_D3)) u_dsel (
        .code     (dly_code_q),
        .load_val (dly_load)
    );

    lcdw_fsm #(.CNT_W(CNT_W), .LD_SETUP(LD_SETUP), .LD_PULSE(LD_PULSE),
               .LD_HOLD(LD_HOLD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_word    (cmd_word),
        .cmd_is_data (cmd_is_data),
        .cmd_exec    (cmd_exec),
        .cmd_delay   (cmd_delay),
        .tmr_zero    (tmr_zero),
        .dly_load    (dly_load),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .dly_code_q  (dly_code_q),
        .ready_o     (ready),
        .init_o      (initialised),
        .e_o         (lcd_e),
        .rs_o        (lcd_rs),
        .data_o      (lcd_data)
    );

    // R8: write-only engine
    assign lcd_rw = 1'b0;

    // R5: enable pulse never overlaps ready
    a_r5_e_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !ready);

    // R5: enable is never high in the cycle right after acceptance (setup)
    a_r5_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_exec) |=> !lcd_e);

endmodule

// File: tb/test_lcdw_byte_driver.sv
module test_lcdw_byte_driver;

    localparam int KHZ   = 1000;
    localparam int SETUP = 1;
    localparam int PULSE = 1;
    localparam int HOLD  = 1;
    localparam int PWR   = 20000;
    localparam int DLY [4] = '{4, 100, 4000, 20000};

    typedef struct {
        logic       rs;
        logic [7:0] data;
        int         tail;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_word = '0;
    logic       cmd_is_data = 1'b0;
    logic       cmd_exec = 1'b0;
    logic [1:0] cmd_delay = '0;
    logic       ready, initialised, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_data;

    int   n_chk = 0;
    int   n_fail = 0;
    int   n_push = 0;
    int   n_pulse = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    lcdw_byte_driver #(.CLK_KHZ(KHZ)) i_lcdw_byte_driver (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_is_data(cmd_is_data),
        .cmd_exec(cmd_exec), .cmd_delay(cmd_delay), .ready(ready),
        .initialised(initialised), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e(lcd_e), .lcd_data(lcd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // driver: waits for ready, issues one strobe, queues the expected item
    task automatic send(input logic rs, input logic [7:0] w, input logic [1:0] code);
        exp_t it;
        while (!ready) @(negedge clk);
        it.rs = rs; it.data = w; it.tail = HOLD + DLY[code];
        sb.push_back(it);
        n_push++;
        cmd_word = w; cmd_is_data = rs; cmd_delay = code; cmd_exec = 1'b1;
        @(negedge clk);
        cmd_exec = 1'b0;
        chk(ready == 1'b0, "R3", "ready after accept", int'(ready), 0);
        chk(lcd_data == w && lcd_rs == rs, "R4", "bus at accept",
            int'({lcd_rs, lcd_data}), int'({rs, w}));
        chk(lcd_e == 1'b0, "R5", "setup before enable", int'(lcd_e), 0);
    endtask

    task automatic wait_powerup();
        for (int i = 1; i < PWR; i++) begin
            @(negedge clk);
            if (i == 100) begin cmd_word = 8'hAA; cmd_exec = 1'b1; end
            if (i == 101) begin
                cmd_exec = 1'b0;
                chk(lcd_data == 8'h00, "R7", "bus after power-up strobe", int'(lcd_data), 0);
            end
        end
        chk(ready == 1'b0 && initialised == 1'b0, "R2", "not ready one edge early",
            int'({ready, initialised}), 0);
        @(negedge clk);
        chk(ready == 1'b1 && initialised == 1'b1, "R2", "ready/initialised on time",
            int'({ready, initialised}), 3);
    endtask

    // monitor: measures each enable pulse and the ready gap after it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && lcd_e) begin
                int width, tail;
                exp_t it;
                n_pulse++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "unexpected enable pulse", 1, 0);
                end else begin
                    it = sb.pop_front();
                    chk(lcd_rs == it.rs, "R4", "rs at enable", int'(lcd_rs), int'(it.rs));
                    chk(lcd_data == it.data, "R4", "data at enable", int'(lcd_data), int'(it.data));
                    chk(lcd_rw == 1'b0, "R8", "rw during write", int'(lcd_rw), 0);
                    width = 0;
                    while (lcd_e) begin width++; @(negedge clk); end
                    chk(width == PULSE, "R5", "enable width", width, PULSE);
                    chk(lcd_data == it.data, "R9", "data held after enable", int'(lcd_data), int'(it.data));
                    tail = 0;
                    while (!ready) begin tail++; @(negedge clk); end
                    chk(tail == it.tail, "R6", "ready gap after enable", tail, it.tail);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        #2;
        chk(lcd_e == 0 && lcd_data == 0 && lcd_rs == 0, "R1", "pins in reset",
            int'({lcd_e, lcd_rs, lcd_data}), 0);
        chk(ready == 0 && initialised == 0, "R1", "status in reset", int'({ready, initialised}), 0);
        chk(lcd_rw == 0, "R8", "rw in reset", int'(lcd_rw), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_powerup();

        send(1'b0, 8'h38, 2'b00);
        send(1'b1, 8'h41, 2'b01);
        send(1'b1, 8'h5A, 2'b10);
        send(1'b0, 8'h01, 2'b11);
        repeat (20) @(negedge clk);
        cmd_word = 8'hEE; cmd_is_data = 1'b1; cmd_exec = 1'b1;
        @(negedge clk);
        cmd_exec = 1'b0;
        chk(lcd_data == 8'h01 && lcd_rs == 1'b0, "R7", "bus after busy strobe",
            int'({lcd_rs, lcd_data}), 1);
        chk(ready == 1'b0, "R7", "still busy", int'(ready), 0);
        while (sb.size() != 0 || !ready) @(negedge clk);
        chk(initialised == 1'b1, "R2", "initialised sticky", int'(initialised), 1);

        // asynchronous reset while idle
        #2 rst_n = 1'b0;
        #1;
        chk(lcd_data == 0 && ready == 0 && initialised == 0 && lcd_e == 0, "R1",
            "async reset clears", int'({ready, initialised, lcd_e, lcd_data}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_powerup();
        send(1'b1, 8'hC3, 2'b00);
        while (sb.size() != 0 || !ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(n_pulse == n_push, "R7", "pulse count", n_pulse, n_push);
        chk(lcd_rw == 1'b0, "R8", "rw at end", int'(lcd_rw), 0);
        finish_run();
    end

endmodule